// File: doc/BRIEF.md
# Shared Buffer Requirement Monitor

This block watches a group of DMA channels that draw entries from one shared data buffer of fixed capacity. It keeps a usage count for each channel, driven by per-channel strobes that take or give back an entry. From that count it tracks two figures. The static requirement is the most entries the channel was holding at any point when it paused on a wait or took the load-lock. The peak is the most entries it has ever held. Their difference is the channel's dynamic requirement.

The combined requirement is the sum of every channel's static requirement plus the single largest dynamic requirement. A plain sum of peaks would overstate the need, because only one channel can be running beyond its static level at a time. The combined value is published every cycle. A flag rises when it goes above the buffer capacity. If that flag stays up while no channel moves any data for a programmable number of cycles, the block reports a watchdog-style abort.

A channel whose run indication is low is treated as stopped or aborted: its counts are cleared and it contributes nothing.

Top module: `bufreq_monitor`

## Requirements
- R1: While reset is held, and until the first strobe takes effect after reset, `total_o`, `over_o` and `abort_o` are all 0.
- R2: For an active channel, a set `alloc_i` bit raises its usage count by one and a set `free_i` bit lowers it by one. Both set in the same cycle leave the count unchanged. The count never goes below 0 or above CAP (512 by default).
- R3: When `mark_i[i]` is set on an active channel, its static requirement becomes the larger of its current static requirement and the usage count held before that cycle's allocate or free.
- R4: A channel's dynamic requirement is its peak usage minus its static requirement. `total_o` equals the sum of all static requirements plus the largest dynamic requirement, which keeps it within (NCH+1)*CAP.
- R5: A channel whose `active_i` bit is 0 has its usage, peak and static requirement cleared. Its strobes are ignored, and it adds nothing to `total_o`.
- R6: A strobe sampled at one rising clock edge is reflected in `total_o` at the following rising edge, two edges after it was applied.
- R7: `over_o` is 1 exactly when `total_o` is greater than CAP, and it changes on the same edge as `total_o`.
- R8: A stall count increases on each edge where `over_o` was 1 and no active channel had an `alloc_i` or `free_i` bit set. `abort_o` is 1 when `over_o` is 1 and the stall count is at least `timeout_i`.
- R9: An edge with any `alloc_i` or `free_i` bit set on an active channel, or with `over_o` at 0, clears the stall count. With `timeout_i` nonzero, `abort_o` is therefore 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| timeout_i | input | TOW | Number of stalled cycles before `abort_o` rises |
| active_i | input | NCH | Bit i is 1 while channel i is running |
| alloc_i | input | NCH | Bit i: channel i takes one buffer entry this cycle |
| free_i | input | NCH | Bit i: channel i returns one buffer entry this cycle |
| mark_i | input | NCH | Bit i: channel i waits or claims the load-lock this cycle |
| total_o | output | TW | Combined buffer requirement |
| over_o | output | 1 | Combined requirement exceeds capacity |
| abort_o | output | 1 | Over-subscribed and stalled for at least `timeout_i` cycles |

## Verification
The properties assume that `timeout_i` stays constant while the block runs, so one cycle of data movement is enough to clear `abort_o`. They also assume that strobes on an inactive channel carry no meaning. The stimulus sets `timeout_i` once, before reset is released. It pulses strobes only at negative edges, and it changes `active_i` only between phases, so every channel update happens at a known edge. The over-subscription phase holds every strobe low long enough for the stall count to pass the timeout. It then moves one entry to confirm that the abort clears.

// File: rtl/bufreq_pkg.sv
package bufreq_pkg;

  // Bits needed to hold values 0..v inclusive.
  function automatic int unsigned cnt_bits(input int unsigned v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/bufreq_chan.sv
// Per-channel usage, peak and static-requirement tracker.
module bufreq_chan #(
  parameter int unsigned CAP = 512,
  parameter int unsigned CW  = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          alloc_i,
  input  logic          free_i,
  input  logic          mark_i,
  output logic [CW-1:0] stat_o,
  output logic [CW-1:0] dyn_o
);
  localparam logic [CW-1:0] CAP_V = CW'(CAP);

  logic [CW-1:0] use_q, use_d;
  logic [CW-1:0] pk_q, pk_d;
  logic [CW-1:0] st_q, st_d;
  logic          en;

  always_comb begin
    use_d = use_q;
    pk_d  = pk_q;
    st_d  = st_q;
    if (!act_i) begin
      use_d = '0;
      pk_d  = '0;
      st_d  = '0;
    end else begin
      if (alloc_i && !free_i && (use_q != CAP_V)) begin
        use_d = use_q + 1'b1;
      end else if (free_i && !alloc_i && (use_q != '0)) begin
        use_d = use_q - 1'b1;
      end
      if (use_d > pk_q) begin
        pk_d = use_d;
      end
      if (mark_i && (use_q > st_q)) begin
        st_d = use_q;
      end
    end
  end

  // Clock enable: update on any strobe, or to clear a stopped channel.
  assign en = act_i ? (alloc_i | free_i | mark_i)
                    : ((use_q != '0) | (pk_q != '0) | (st_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_q <= '0;
      pk_q  <= '0;
      st_q  <= '0;
    end else if (en) begin
      use_q <= use_d;
      pk_q  <= pk_d;
      st_q  <= st_d;
    end
  end

  assign stat_o = st_q;
  assign dyn_o  = pk_q - st_q;
endmodule

// File: rtl/bufreq_total.sv
// Sum of static requirements plus the largest dynamic requirement, registered.
module bufreq_total #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CAP = 512,
  parameter int unsigned CW  = 10,
  parameter int unsigned TW  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0][CW-1:0]  stat_i,
  input  logic [NCH-1:0][CW-1:0]  dyn_i,
  output logic [TW-1:0]           total_o,
  output logic                    over_o
);
  logic [TW-1:0] sum_c;
  logic [CW-1:0] max_c;
  logic [TW-1:0] tot_d, tot_q;
  logic          ov_d, ov_q;
  logic          en;

  always_comb begin
    sum_c = '0;
    max_c = '0;
    for (int i = 0; i < NCH; i++) begin
      sum_c = sum_c + TW'(stat_i[i]);
      if (dyn_i[i] > max_c) begin
        max_c = dyn_i[i];
      end
    end
    tot_d = sum_c + TW'(max_c);
    ov_d  = (tot_d > TW'(CAP));
  end

  assign en = (tot_d != tot_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tot_q <= '0;
      ov_q  <= 1'b0;
    end else if (en) begin
      tot_q <= tot_d;
      ov_q  <= ov_d;
    end
  end

  assign total_o = tot_q;
  assign over_o  = ov_q;
endmodule

// File: rtl/bufreq_wdog.sv
// Stall counter: runs while over-subscribed with no data movement.
module bufreq_wdog #(
  parameter int unsigned TOW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           over_i,
  input  logic           prog_i,
  input  logic [TOW-1:0] timeout_i,
  output logic           abort_o
);
  logic [TOW-1:0] cnt_q, cnt_d;
  logic           en;

  always_comb begin
    if (!over_i || prog_i) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  assign en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

  assign abort_o = over_i && (cnt_q >= timeout_i);
endmodule

// File: rtl/bufreq_monitor.sv
module bufreq_monitor #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CAP = 512,
  parameter int unsigned TOW = 16,
  localparam int unsigned CW = bufreq_pkg::cnt_bits(CAP),
  localparam int unsigned TW = bufreq_pkg::cnt_bits((NCH + 1) * CAP)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [TOW-1:0] timeout_i,
  input  logic [NCH-1:0] active_i,
  input  logic [NCH-1:0] alloc_i,
  input  logic [NCH-1:0] free_i,
  input  logic [NCH-1:0] mark_i,
  output logic [TW-1:0]  total_o,
  output logic           over_o,
  output logic           abort_o
);
  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rs_q[1];

  logic [NCH-1:0][CW-1:0] stat_w;
  logic [NCH-1:0][CW-1:0] dyn_w;
  logic                   prog_w;
  logic                   over_w;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    bufreq_chan #(.CAP(CAP), .CW(CW)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .act_i   (active_i[g]),
      .alloc_i (alloc_i[g]),
      .free_i  (free_i[g]),
      .mark_i  (mark_i[g]),
      .stat_o  (stat_w[g]),
      .dyn_o   (dyn_w[g])
    );
  end

  bufreq_total #(.NCH(NCH), .CAP(CAP), .CW(CW), .TW(TW)) u_total (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .stat_i  (stat_w),
    .dyn_i   (dyn_w),
    .total_o (total_o),
    .over_o  (over_w)
  );

  assign prog_w = |((alloc_i | free_i) & active_i);

  bufreq_wdog #(.TOW(TOW)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .over_i    (over_w),
    .prog_i    (prog_w),
    .timeout_i (timeout_i),
    .abort_o   (abort_o)
  );

  assign over_o = over_w;
endmodule

// File: rtl/bufreq_monitor_chk.sv
module bufreq_monitor_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CAP = 512,
  parameter int unsigned TOW = 16,
  parameter int unsigned TW  = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [TOW-1:0] timeout_i,
  input logic [NCH-1:0] active_i,
  input logic [NCH-1:0] alloc_i,
  input logic [NCH-1:0] free_i,
  input logic [TW-1:0]  total_o,
  input logic           over_o,
  input logic           abort_o
);
  AST_OVER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    over_o == (total_o > TW'(CAP))); // R7

  AST_ABORT_NEEDS_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> over_o); // R8

  AST_PROGRESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((timeout_i != '0) && (|((alloc_i | free_i) & active_i))) |=> !abort_o); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i == '0) |=> ##1 (total_o == '0)); // R5

  AST_TOTAL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    total_o <= TW'((NCH + 1) * CAP)); // R4
endmodule

bind bufreq_monitor bufreq_monitor_chk #(
  .NCH(NCH), .CAP(CAP), .TOW(TOW), .TW(TW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .timeout_i (timeout_i),
  .active_i  (active_i),
  .alloc_i   (alloc_i),
  .free_i    (free_i),
  .total_o   (total_o),
  .over_o    (over_o),
  .abort_o   (abort_o)
);

// File: tb/bufreq_monitor_bench.sv
module bufreq_monitor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CAP = 512;
  localparam int TOW = 16;
  localparam int TW  = $clog2((NCH + 1) * CAP + 1);
  localparam int TMO = 5;

  logic           clk;
  logic           rst_n;
  logic [TOW-1:0] timeout_i;
  logic [NCH-1:0] active_i, alloc_i, free_i, mark_i;
  logic [TW-1:0]  total_o;
  logic           over_o, abort_o;

  bufreq_monitor #(.NCH(NCH), .CAP(CAP), .TOW(TOW)) u_bufreq_monitor (
    .clk(clk), .rst_n(rst_n), .timeout_i(timeout_i), .active_i(active_i),
    .alloc_i(alloc_i), .free_i(free_i), .mark_i(mark_i),
    .total_o(total_o), .over_o(over_o), .abort_o(abort_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    tot;
    bit    ov;
    bit    ab;
    string tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  // Reference model state, built from the requirements.
  int m_use[NCH];
  int m_pk[NCH];
  int m_st[NCH];
  int m_cnt;
  bit m_ov;
  logic [NCH-1:0] act_v;

  // Monitor: compare queued expectations once their edge has passed.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (int'(total_o) != e.tot || over_o != e.ov || abort_o != e.ab) begin
        fails++;
        $display("FAIL %s cyc %0d: total/over/abort actual %0d/%0b/%0b expected %0d/%0b/%0b",
                 e.tag, cyc, total_o, over_o, abort_o, e.tot, e.ov, e.ab);
      end
    end
  end

  // Driver: apply one cycle of strobes and push the outputs expected after that edge.
  task automatic step(input logic [NCH-1:0] al, input logic [NCH-1:0] fr,
                      input logic [NCH-1:0] mk, input string tag);
    exp_t e;
    int   sum, mx, tot;
    bit   prog;
    alloc_i  = al;
    free_i   = fr;
    mark_i   = mk;
    active_i = act_v;
    prog = |((al | fr) & act_v);
    m_cnt = (!m_ov || prog) ? 0 : ((m_cnt < 65535) ? m_cnt + 1 : m_cnt);
    sum = 0;
    mx  = 0;
    for (int i = 0; i < NCH; i++) begin
      sum += m_st[i];
      if (m_pk[i] - m_st[i] > mx) mx = m_pk[i] - m_st[i];
    end
    tot  = sum + mx;
    m_ov = (tot > CAP);
    for (int i = 0; i < NCH; i++) begin
      if (!act_v[i]) begin
        m_use[i] = 0; m_pk[i] = 0; m_st[i] = 0;
      end else begin
        int prior;
        prior = m_use[i];
        if (al[i] && !fr[i] && m_use[i] < CAP) m_use[i]++;
        else if (fr[i] && !al[i] && m_use[i] > 0) m_use[i]--;
        if (m_use[i] > m_pk[i]) m_pk[i] = m_use[i];
        if (mk[i] && prior > m_st[i]) m_st[i] = prior;
      end
    end
    e.at  = cyc + 1;
    e.tot = tot;
    e.ov  = m_ov;
    e.ab  = m_ov && (m_cnt >= TMO);
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step('0, '0, '0, tag);
  endtask

  task automatic rep(input int ch, input int n, input bit a, input bit f,
                     input string tag);
    for (int k = 0; k < n; k++) begin
      logic [NCH-1:0] v;
      v = '0;
      v[ch] = 1'b1;
      step(a ? v : '0, f ? v : '0, '0, tag);
    end
  endtask

  task automatic mark1(input int ch, input string tag);
    logic [NCH-1:0] v;
    v = '0;
    v[ch] = 1'b1;
    step('0, '0, v, tag);
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          fails++;
          checks++;
          $display("FAIL watchdog: run did not complete, actual hung expected finished");
          $display("%0d/%0d checks passed", checks - fails, checks);
          $finish;
        end
      end
    join_none
  end

  initial begin
    rst_n = 1'b0;
    timeout_i = TOW'(TMO);
    active_i = '0; alloc_i = '0; free_i = '0; mark_i = '0;
    act_v = '0;
    for (int i = 0; i < NCH; i++) begin m_use[i] = 0; m_pk[i] = 0; m_st[i] = 0; end
    m_cnt = 0; m_ov = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (total_o != '0 || over_o || abort_o) begin
      fails++;
      $display("FAIL R1: reset outputs actual %0d/%0b/%0b expected 0/0/0", total_o, over_o, abort_o);
    end
    rst_n = 1'b1;
    idle(3, "R1");

    // R2: counting, cancel, floor
    act_v = 4'b0001;
    rep(0, 2, 0, 1, "R2");
    rep(0, 3, 1, 0, "R2");
    rep(0, 2, 1, 1, "R2");
    rep(0, 1, 0, 1, "R2");
    rep(0, 2, 1, 0, "R6");
    idle(2, "R6");

    // R3/R4: static and dynamic requirements
    mark1(0, "R3");
    rep(0, 3, 1, 0, "R4");
    rep(0, 7, 0, 1, "R4");
    mark1(0, "R3");
    act_v = 4'b0011;
    rep(1, 10, 1, 0, "R4");
    mark1(1, "R3");
    rep(1, 10, 0, 1, "R4");
    rep(1, 4, 1, 0, "R4");
    idle(2, "R4");

    // R5: stop clears, strobes ignored while inactive
    act_v = 4'b0010;
    step(4'b0001, '0, 4'b0001, "R5");
    idle(2, "R5");
    act_v = '0;
    step(4'b1111, '0, 4'b1111, "R5");
    idle(2, "R5");

    // R2: ceiling at CAP
    act_v = 4'b0100;
    rep(2, CAP + 6, 1, 0, "R2");
    idle(2, "R2");
    act_v = '0;
    idle(2, "R5");

    // R7/R8/R9: over-subscription and abort
    act_v = 4'b0111;
    for (int c = 0; c < 3; c++) begin
      rep(c, 200, 1, 0, "R7");
      mark1(c, "R7");
    end
    idle(TMO + 4, "R8");
    rep(0, 1, 0, 1, "R9");
    idle(2, "R9");
    idle(TMO + 2, "R8");
    act_v = '0;
    idle(4, "R5");

    repeat (2) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      checks++;
      $display("FAIL R6: unchecked items actual %0d expected 0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule